// File: doc/BRIEF.md
# DAC Volume and Mute Combiner

This block keeps the playback gain settings of an eight-channel DAC. Each channel has a volume and a mute flag. Each side has a master volume and a master mute flag: even channels belong to the left side and odd channels to the right side. When a host command changes a setting, the block works out the attenuation code of every channel the change affects. It does this by multiplying channel gain by master gain and looking the result up in a logarithmic attenuation curve. For each affected channel it then issues a pair of register writes to a serial control-port writer over a valid/ready handshake: a latch write first, then an update write.

A separate digital master path converts one level into an 8-bit code. It issues that code to a fixed register as a latch/update pair, but only when the code differs from the one last issued. Host commands arrive one at a time. A command is taken only while `busy` is low, and `busy` stays high until every write the previous command caused has been accepted. After reset the block mutes everything and writes all eight channels in order, with `busy` high the whole time.

Top module: `vol_combiner`

## Requirements
- R1: From reset, every channel and both masters are muted, the digital code is 0 and `busy` is high. The block issues sixteen writes: channels 0 to 7 in ascending order, each written with data 0x000 and then 0x180. After that `busy` goes low.
- R2: A write is transferred on a clock edge where `wrValid` and `wrReady` are both high. While `wrValid` is high and `wrReady` is low, `wrValid`, `wrAddr` and `wrData` hold their values.
- R3: A channel's code is 0 if its own mute flag or its side's master mute flag is set. Otherwise the code is 127 - L[((vol*master)/127) & 0xFF], where L(0) = 127 and L(x) = floor(20*log10(255/x)) for x from 1 to 255.
- R4: A channel update is two writes to address = channel index. The first has data = code, with bits 8:7 at 00. The second has data = code | 0x180.
- R5: Master index 0 is the left side and governs channels 0, 2, 4, 6. Master index 1 is the right side and governs channels 1, 3, 5, 7. A change to one side's master volume or mute rewrites that side's four channels in ascending order.
- R6: A change to a channel's volume or mute rewrites only that channel.
- R7: The digital level maps to a code: level 0 gives code 0, a level n from 1 to 128 gives (n+127) & 0xFF, and a level above 128 is treated as 128. The code is written to address 0x11, first as-is and then ORed with 0x100.
- R8: A command that leaves its stored setting unchanged produces no writes. This includes a digital level whose code equals the stored code.
- R9: A command is taken only on an edge where `cmdValid` is high and `busy` is low. A command presented while `busy` is high has no effect on any setting.
- R10: Command encoding. `cmdKind` 0 sets channel `cmdIdx`'s volume to `cmdData[6:0]`. Kind 1 sets that channel's mute to `cmdData[0]`, where 1 means muted. Kind 2 sets master `cmdIdx[0]`'s volume to `cmdData[7:0]`. Kind 3 sets that master's mute to `cmdData[0]`. Kind 4 sets the digital level to `cmdData`. Kinds 5 to 7 change nothing and produce no writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Host command present |
| cmdKind | input | 3 | Command kind (R10) |
| cmdIdx | input | 3 | Channel index, or master side in bit 0 |
| cmdData | input | 8 | Command value |
| busy | output | 1 | Write sequence in progress; commands not taken |
| wrValid | output | 1 | Register write request valid |
| wrReady | input | 1 | Control-port writer accepts the write |
| wrAddr | output | 7 | Register address |
| wrData | output | 9 | Register value |

## Verification
The bench builds the block with its default parameters: eight channels, a 7-bit channel volume and an 8-bit master volume. With these values a full-scale master of 255 times a full channel volume of 127 reaches curve index 255, and a small product reaches index 0. Both ends of the attenuation curve are therefore exercised, together with ordinary mid-range points. Writer back-pressure is applied as a pseudo-random ready pattern while the stimulus table runs, and as a long stall while a command arrives during `busy`.

// File: rtl/vc_pkg.sv
package vc_pkg;

  localparam int CHAN_IDX_W = 3;
  localparam int ROM_STEPS  = 48;

  localparam logic [2:0] K_CHAN_VOL  = 3'd0;
  localparam logic [2:0] K_CHAN_MUTE = 3'd1;
  localparam logic [2:0] K_MST_VOL   = 3'd2;
  localparam logic [2:0] K_MST_MUTE  = 3'd3;
  localparam logic [2:0] K_DIG_LVL   = 3'd4;

  typedef enum logic [1:0] {
    SEQ_ONE,
    SEQ_SIDE,
    SEQ_ALL,
    SEQ_DIG
  } seqMode_e;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic                  load;
    logic [CHAN_IDX_W-1:0] chan;
    logic                  upd;
    logic                  dig;
  } ctrlStb_t;

  // Threshold k (1..ROM_STEPS) is the largest index whose attenuation is at
  // least k dB. The curve value at index x is the number of thresholds >= x.
  function automatic logic [ROM_STEPS*8-1:0] buildThresh();
    logic [ROM_STEPS*8-1:0] t;
    t = '0;
    for (int k = 1; k <= ROM_STEPS; k++)
      t[(k-1)*8 +: 8] = 8'($rtoi(255.0 * (10.0 ** (-real'(k) / 20.0))));
    return t;
  endfunction

  localparam logic [ROM_STEPS*8-1:0] ATTEN_THRESH = buildThresh();

endpackage

// File: rtl/vc_datapath.sv
module vc_datapath
  import vc_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int VOL_W    = 7,
  parameter int MST_W    = 8,
  parameter int CMD_W    = 8,
  parameter int CODE_W   = 7,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 9,
  parameter int DIG_W    = 8,
  parameter int DIG_MAX  = 128,
  parameter logic [ADDR_W-1:0] DIG_REG = 7'h11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStb_t              stb,
  input  logic [2:0]            cmdKind,
  input  logic [CHAN_IDX_W-1:0] cmdIdx,
  input  logic [CMD_W-1:0]      cmdData,
  output logic                  cmdChanges,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [DATA_W-1:0]     wrData
);

  localparam int PROD_W   = VOL_W + MST_W;
  localparam int IDX_W    = 8;
  localparam int VOL_FULL = (1 << VOL_W) - 1;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int DIG_OFS  = 127;

  logic [VOL_W-1:0]    chanVol [NUM_CHAN];
  logic [NUM_CHAN-1:0] chanMute;
  logic [MST_W-1:0]    mstVol  [2];
  logic [1:0]          mstMute;
  logic [DIG_W-1:0]    digCode;

  // digital level to code, with saturation at the top level
  logic [CMD_W-1:0] digLvl;
  logic [DIG_W-1:0] newDig;
  always_comb begin
    digLvl = (cmdData > CMD_W'(DIG_MAX)) ? CMD_W'(DIG_MAX) : cmdData;
    newDig = (digLvl == '0) ? '0 : DIG_W'(digLvl + CMD_W'(DIG_OFS));
  end

  // does the offered command alter stored state
  always_comb begin
    case (cmdKind)
      K_CHAN_VOL:  cmdChanges = chanVol[cmdIdx] != cmdData[VOL_W-1:0];
      K_CHAN_MUTE: cmdChanges = chanMute[cmdIdx] != cmdData[0];
      K_MST_VOL:   cmdChanges = mstVol[cmdIdx[0]] != cmdData[MST_W-1:0];
      K_MST_MUTE:  cmdChanges = mstMute[cmdIdx[0]] != cmdData[0];
      K_DIG_LVL:   cmdChanges = digCode != newDig;
      default:     cmdChanges = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CHAN; c++) chanVol[c] <= '0;
      chanMute  <= '1;
      mstVol[0] <= '0;
      mstVol[1] <= '0;
      mstMute   <= 2'b11;
      digCode   <= '0;
    end else if (stb.load) begin
      case (cmdKind)
        K_CHAN_VOL:  chanVol[cmdIdx]    <= cmdData[VOL_W-1:0];
        K_CHAN_MUTE: chanMute[cmdIdx]   <= cmdData[0];
        K_MST_VOL:   mstVol[cmdIdx[0]]  <= cmdData[MST_W-1:0];
        K_MST_MUTE:  mstMute[cmdIdx[0]] <= cmdData[0];
        K_DIG_LVL:   digCode            <= newDig;
        default: ;
      endcase
    end
  end

  // gain product and curve index for the channel being written
  logic              selSide;
  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] quot;
  logic [IDX_W-1:0]  romIdx;
  always_comb begin
    selSide = stb.chan[0];
    prod    = PROD_W'(chanVol[stb.chan]) * PROD_W'(mstVol[selSide]);
    quot    = prod / PROD_W'(VOL_FULL);
    romIdx  = IDX_W'(quot);
  end

  // logarithmic curve as a count of passed thresholds
  logic [CODE_W-1:0] stepCnt;
  logic [CODE_W-1:0] atten;
  always_comb begin
    stepCnt = '0;
    for (int k = 0; k < ROM_STEPS; k++)
      if (romIdx <= ATTEN_THRESH[k*8 +: 8]) stepCnt = stepCnt + CODE_W'(1);
    atten = (romIdx == '0) ? CODE_W'(CODE_MAX) : stepCnt;
  end

  logic              chanSilent;
  logic [CODE_W-1:0] chanCode;
  always_comb begin
    chanSilent = chanMute[stb.chan] | mstMute[selSide];
    chanCode   = chanSilent ? '0 : CODE_W'(CODE_MAX) - atten;
  end

  always_comb begin
    if (stb.dig) begin
      wrAddr = DIG_REG;
      wrData = {stb.upd, digCode};
    end else begin
      wrAddr = ADDR_W'(stb.chan);
      wrData = {stb.upd, stb.upd, chanCode};
    end
  end

endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [2:0]            cmdKind,
  input  logic [CHAN_IDX_W-1:0] cmdIdx,
  input  logic                  cmdChanges,
  input  logic                  wrReady,
  output logic                  wrValid,
  output logic                  busy,
  output ctrlStb_t              stb
);

  localparam int CNT_W = CHAN_IDX_W + 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_CHAN - 1);

  logic                  sending;
  seqMode_e              mode;
  logic [CHAN_IDX_W-1:0] chan;
  logic                  upd;

  logic accept;
  logic lastChan;
  logic [CHAN_IDX_W-1:0] nextChan;

  always_comb begin
    accept = cmdValid & ~sending;
    case (mode)
      SEQ_SIDE: begin
        lastChan = ({1'b0, chan} + CNT_W'(2)) > LAST_IDX;
        nextChan = chan + CHAN_IDX_W'(2);
      end
      SEQ_ALL: begin
        lastChan = {1'b0, chan} == LAST_IDX;
        nextChan = chan + CHAN_IDX_W'(1);
      end
      default: begin
        lastChan = 1'b1;
        nextChan = chan;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sending <= 1'b1;
      mode    <= SEQ_ALL;
      chan    <= '0;
      upd     <= 1'b0;
    end else if (!sending) begin
      if (accept && cmdChanges) begin
        sending <= 1'b1;
        upd     <= 1'b0;
        case (cmdKind)
          K_MST_VOL, K_MST_MUTE: begin
            mode <= SEQ_SIDE;
            chan <= CHAN_IDX_W'(cmdIdx[0]);
          end
          K_DIG_LVL: begin
            mode <= SEQ_DIG;
            chan <= '0;
          end
          default: begin
            mode <= SEQ_ONE;
            chan <= cmdIdx;
          end
        endcase
      end
    end else if (wrReady) begin
      if (!upd) begin
        upd <= 1'b1;
      end else begin
        upd <= 1'b0;
        if (lastChan) sending <= 1'b0;
        else          chan    <= nextChan;
      end
    end
  end

  always_comb begin
    wrValid  = sending;
    busy     = sending;
    stb.load = accept;
    stb.chan = chan;
    stb.upd  = upd;
    stb.dig  = (mode == SEQ_DIG);
  end

endmodule

// File: rtl/vol_combiner.sv
module vol_combiner
  import vc_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int VOL_W    = 7,
  parameter int MST_W    = 8,
  parameter int CMD_W    = 8,
  parameter int CODE_W   = 7,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 9,
  parameter int DIG_W    = 8,
  parameter int DIG_MAX  = 128,
  parameter logic [ADDR_W-1:0] DIG_REG = 7'h11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmdValid,
  input  logic [2:0]            cmdKind,
  input  logic [CHAN_IDX_W-1:0] cmdIdx,
  input  logic [CMD_W-1:0]      cmdData,
  output logic                  busy,
  output logic                  wrValid,
  input  logic                  wrReady,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [DATA_W-1:0]     wrData
);

  ctrlStb_t stb;
  logic     cmdChanges;

  vc_ctrl #(
    .NUM_CHAN(NUM_CHAN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdKind   (cmdKind),
    .cmdIdx    (cmdIdx),
    .cmdChanges(cmdChanges),
    .wrReady   (wrReady),
    .wrValid   (wrValid),
    .busy      (busy),
    .stb       (stb)
  );

  vc_datapath #(
    .NUM_CHAN(NUM_CHAN),
    .VOL_W   (VOL_W),
    .MST_W   (MST_W),
    .CMD_W   (CMD_W),
    .CODE_W  (CODE_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .DIG_W   (DIG_W),
    .DIG_MAX (DIG_MAX),
    .DIG_REG (DIG_REG)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdKind   (cmdKind),
    .cmdIdx    (cmdIdx),
    .cmdData   (cmdData),
    .cmdChanges(cmdChanges),
    .wrAddr    (wrAddr),
    .wrData    (wrData)
  );

endmodule

// File: rtl/vol_combiner_chk.sv
module vol_combiner_chk #(
  parameter int NUM_CHAN = 8,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 9,
  parameter logic [ADDR_W-1:0] DIG_REG = 7'h11
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              wrValid,
  input logic              wrReady,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData
);

  // R2: a stalled request holds its contents
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  // R4: an accepted latch write is followed by its update write
  p_pair_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && !wrData[DATA_W-1]) |=>
      (wrValid && wrData[DATA_W-1] && wrAddr == $past(wrAddr) &&
       wrData[6:0] == $past(wrData[6:0])));

  // R4: channel writes carry both update flags equal
  p_chan_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrAddr < ADDR_W'(NUM_CHAN)) |-> (wrData[DATA_W-1] == wrData[DATA_W-2]));

  // R5: only channel registers and the digital register are addressed
  p_addr_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrAddr < ADDR_W'(NUM_CHAN) || wrAddr == DIG_REG));

  // R9: no write request while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wrValid);

endmodule

bind vol_combiner vol_combiner_chk #(
  .NUM_CHAN(NUM_CHAN),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .DIG_REG (DIG_REG)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .wrValid(wrValid),
  .wrReady(wrReady),
  .wrAddr (wrAddr),
  .wrData (wrData)
);

// File: tb/tb_vol_combiner.sv
module tb_vol_combiner;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic       cmdValid = 1'b0;
  logic [2:0] cmdKind = '0;
  logic [2:0] cmdIdx = '0;
  logic [7:0] cmdData = '0;
  logic       wrReady = 1'b0;
  logic       busy, wrValid;
  logic [6:0] wrAddr;
  logic [8:0] wrData;

  vol_combiner dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdIdx(cmdIdx), .cmdData(cmdData), .busy(busy), .wrValid(wrValid),
    .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData)
  );

  int nChecks = 0;
  int nBad = 0;

  // writer ready: 0 low, 1 high, 2 pseudo-random
  int readyMode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wrReady = (readyMode == 1) || (readyMode == 2 && lfsr[0]);
  end

  // write log and hold monitor
  logic [6:0] logA [64];
  logic [8:0] logD [64];
  int logN = 0;
  int holdErr = 0;
  logic prevHold = 1'b0;
  logic [6:0] prevA = '0;
  logic [8:0] prevD = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevHold && !(wrValid && wrAddr == prevA && wrData == prevD)) holdErr++;
      prevHold = wrValid && !wrReady;
      prevA = wrAddr;
      prevD = wrData;
      if (wrValid && wrReady) begin
        if (logN < 64) begin
          logA[logN] = wrAddr;
          logD[logN] = wrData;
        end
        logN++;
      end
    end else begin
      prevHold = 1'b0;
    end
  end

  // reference model
  int mVol [2];
  bit mMute [2];
  int cVol [8];
  bit cMute [8];
  int dCode;
  int expA [64];
  int expD [64];
  int expN;

  function automatic int romRef(int x);
    if (x == 0) return 127;
    return $rtoi($floor(20.0 * $log10(255.0 / x)));
  endfunction

  function automatic int codeRef(int c);
    if (cMute[c] || mMute[c % 2]) return 0;
    return 127 - romRef(((cVol[c] * mVol[c % 2]) / 127) & 255);
  endfunction

  task automatic pushChan(int c);
    expA[expN] = c;     expD[expN] = codeRef(c);
    expA[expN+1] = c;   expD[expN+1] = codeRef(c) | 'h180;
    expN += 2;
  endtask

  task automatic modelCmd(int k, int i, int d);
    int lvl, nc;
    expN = 0;
    case (k)
      0: if (cVol[i] != (d & 127)) begin cVol[i] = d & 127; pushChan(i); end
      1: if (cMute[i] != d[0]) begin cMute[i] = d[0]; pushChan(i); end
      2, 3: begin
        if (k == 2 && mVol[i % 2] != d) begin
          mVol[i % 2] = d;
          for (int c = i % 2; c < 8; c += 2) pushChan(c);
        end
        if (k == 3 && mMute[i % 2] != d[0]) begin
          mMute[i % 2] = d[0];
          for (int c = i % 2; c < 8; c += 2) pushChan(c);
        end
      end
      4: begin
        lvl = (d > 128) ? 128 : d;
        nc = (lvl == 0) ? 0 : ((lvl + 127) & 255);
        if (nc != dCode) begin
          dCode = nc;
          expA[0] = 'h11; expD[0] = nc;
          expA[1] = 'h11; expD[1] = nc | 'h100;
          expN = 2;
        end
      end
      default: ;
    endcase
  endtask

  task automatic waitIdle();
    @(posedge clk); #1;
    while (busy) begin @(posedge clk); #1; end
  endtask

  task automatic checkLog(string tag);
    bit ok;
    ok = (logN == expN);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: write count actual=%0d expected=%0d", tag, logN, expN);
      return;
    end
    for (int n = 0; n < expN; n++) begin
      if (logA[n] != 7'(expA[n]) || logD[n] != 9'(expD[n])) begin
        nBad++;
        $display("FAIL %s: write %0d actual=%h/%h expected=%h/%h",
                 tag, n, logA[n], logD[n], 7'(expA[n]), 9'(expD[n]));
        return;
      end
    end
  endtask

  task automatic sendCmd(int k, int i, int d, string tag);
    waitIdle();
    logN = 0;
    modelCmd(k, i, d);
    cmdKind = 3'(k); cmdIdx = 3'(i); cmdData = 8'(d); cmdValid = 1'b1;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    while (busy) begin @(posedge clk); #1; end
    checkLog(tag);
  endtask

  // stimulus table {kind, index, data}
  localparam int NVEC = 20;
  localparam logic [13:0] VEC [NVEC] = '{
    {3'd2, 3'd0, 8'd127}, {3'd3, 3'd0, 8'd0},   {3'd1, 3'd0, 8'd0},
    {3'd0, 3'd0, 8'd127}, {3'd1, 3'd2, 8'd0},   {3'd0, 3'd2, 8'd64},
    {3'd2, 3'd0, 8'd255}, {3'd2, 3'd1, 8'd100}, {3'd3, 3'd1, 8'd0},
    {3'd1, 3'd7, 8'd0},   {3'd0, 3'd7, 8'd1},   {3'd0, 3'd7, 8'd50},
    {3'd4, 3'd0, 8'd128}, {3'd4, 3'd0, 8'd1},   {3'd0, 3'd0, 8'd127},
    {3'd5, 3'd3, 8'd9},   {3'd4, 3'd0, 8'd1},   {3'd4, 3'd0, 8'd200},
    {3'd3, 3'd0, 8'd1},   {3'd1, 3'd4, 8'd0}
  };

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nBad++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    for (int s = 0; s < 2; s++) begin mVol[s] = 0; mMute[s] = 1; end
    for (int c = 0; c < 8; c++) begin cVol[c] = 0; cMute[c] = 1; end
    dCode = 0;

    // R1: reset state, first request presented before any ready
    readyMode = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (!(busy && wrValid && wrAddr == 7'd0 && wrData == 9'h000)) begin
      nBad++;
      $display("FAIL R1: after reset busy/valid/addr/data actual=%b/%b/%h/%h expected=1/1/00/000",
               busy, wrValid, wrAddr, wrData);
    end
    logN = 0;
    expN = 0;
    for (int c = 0; c < 8; c++) pushChan(c);
    readyMode = 1;
    waitIdle();
    checkLog("R1 reset sweep");

    // table walk under random back-pressure (R3 R4 on every channel write)
    readyMode = 2;
    for (int v = 0; v < NVEC; v++) begin
      int k, i, d;
      string tag;
      k = int'(VEC[v][13:11]); i = int'(VEC[v][10:8]); d = int'(VEC[v][7:0]);
      case (k)
        0, 1: tag = "R6";
        2, 3: tag = "R5";
        4: tag = "R7";
        default: tag = "R10";
      endcase
      if (v == 14 || v == 16) tag = "R8";
      sendCmd(k, i, d, $sformatf("vec %0d %s R3 R4", v, tag));
    end

    // R9: command presented while busy is ignored
    readyMode = 0;
    waitIdle();
    logN = 0;
    modelCmd(4, 0, 64);
    cmdKind = 3'd4; cmdIdx = 3'd0; cmdData = 8'd64; cmdValid = 1'b1;
    @(posedge clk); #1;
    cmdKind = 3'd0; cmdIdx = 3'd3; cmdData = 8'd90;
    repeat (3) begin
      @(negedge clk);
      nChecks++;
      if (!busy) begin
        nBad++;
        $display("FAIL R9: busy during stall actual=%b expected=1", busy);
      end
      @(posedge clk); #1;
    end
    cmdValid = 1'b0;
    readyMode = 1;
    while (busy) begin @(posedge clk); #1; end
    checkLog("R9 digital pair with ignored command");
    sendCmd(1, 3, 0, "R9 ignored volume left no trace");

    // R2: stalled requests never changed
    nChecks++;
    if (holdErr != 0) begin
      nBad++;
      $display("FAIL R2: hold violations actual=%0d expected=0", holdErr);
    end

    finishRun();
  end

endmodule